// File: doc/BRIEF.md
# Half-Bridge Gate Control Sequencer

This block sequences the two gate-enable outputs of a synchronous buck power stage. External comparators reduce a three-level PWM command and a three-level enable line to 2-bit level codes. A supply-good flag and two gate-discharge flags, one per switch, arrive as plain bits. From these inputs the block decides, cycle by cycle, which switch may conduct. It never turns a switch on before the opposite gate has been sensed as discharged and a programmable guard time has passed.

The enable line has three functions. At its low level it shuts the stage down. At its middle level it keeps the stage powered but holds both switches off, which is used for body-diode braking. At its high level it hands control to the PWM command. After each start-up, the block waits out a programmable settling interval before it acts on PWM. A middle-level PWM code parks both switches for a guard time. If a discharge flag stays false for too long, the block latches a fault that holds both switches off.

Top module: `hbg_gate_seq`

## Requirements
- R1: With the enable code at low (2'b00), both drive outputs are 0 from the third clock edge after the change, PWM has no effect, and the settling interval restarts from zero on the next enable.
- R2: With the enable code at mid (2'b01), both drive outputs are 0 from the third clock edge after the change. The settling interval is not restarted, so a return to high (2'b10) answers PWM without a new settling wait.
- R3: With enable high, supply good and the settling interval complete, a PWM code of high (2'b10) leaves only `hs_drive` at 1 in steady state, and a PWM code of low (2'b00) leaves only `ls_drive` at 1.
- R4: On a PWM change to high, `ls_drive` falls first. `hs_drive` rises only after `ls_gate_low` has been seen true for HS_DLY consecutive cycles at the synchronizer output.
- R5: On a PWM change to low, `hs_drive` falls first. `ls_drive` rises only after `hs_gate_low` has been seen true for LS_DLY consecutive cycles at the synchronizer output.
- R6: A PWM code of mid (2'b01) forces both outputs to 0 for MID_DLY cycles. If PWM is still mid after that, both outputs stay 0. If PWM has left mid, the normal guarded sequence for the new level follows.
- R7: The unused level code 2'b11 on either input behaves exactly as mid.
- R8: While `supply_good` is 0, both outputs are 0 whatever the enable and PWM codes are. After the flag returns to 1, a full settling interval is applied again.
- R9: After the block becomes enabled (enable not low, supply good), both outputs stay 0 until WAKE_CYC cycles have passed.
- R10: If the awaited discharge flag stays false for TMO_CYC cycles, `fb_fault` goes to 1 and both outputs stay 0. The fault is cleared only by enable low or by reset.
- R11: Every input passes through SYNC_STAGES flip-flops. With the default of two stages, an input change first affects the outputs at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | PWM level code: 00 low, 01 mid, 10 high, 11 treated as mid |
| en_code | input | 2 | Enable level code, same encoding as pwm_code |
| supply_good | input | 1 | 1 while the supply is above its lockout level |
| hs_gate_low | input | 1 | 1 when the high-side gate-to-switch voltage is below its off threshold |
| ls_gate_low | input | 1 | 1 when the low-side gate voltage is below its off threshold |
| hs_drive | output | 1 | High-side gate enable |
| ls_drive | output | 1 | Low-side gate enable |
| fb_fault | output | 1 | Sticky discharge-timeout fault |

## Verification
The bench builds the block with HS_DLY=3, LS_DLY=2, MID_DLY=4, WAKE_CYC=20 and TMO_CYC=10. These values are small enough that a settling interval, a fault timeout and several guard periods all fit into a few hundred cycles. They also differ from one another, so a swap of the high-side and low-side delays, or a mid hold cut short, moves an output edge by a cycle that the bench can see. The gate-discharge flags come from a one-cycle model of the power stage. For the timeout cases the model is overridden, so the adaptive wait can be observed both when the flag is slow and when it is stuck.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

   // Level codes delivered by the external three-level comparators
   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_MID  = 2'b01,
      LVL_HIGH = 2'b10
   } lvl_e;

   // Request derived from the PWM level
   typedef enum logic [1:0] {
      CMD_HS  = 2'b00,
      CMD_LS  = 2'b01,
      CMD_MID = 2'b10
   } cmd_e;

   // Phases of the non-overlap sequencer
   typedef enum logic [2:0] {
      PH_IDLE     = 3'd0,
      PH_HS_ON    = 3'd1,
      PH_LS_ON    = 3'd2,
      PH_TO_HS    = 3'd3,
      PH_TO_LS    = 3'd4,
      PH_MID_HOLD = 3'd5
   } phase_e;

   // The unused code 2'b11 folds onto mid
   function automatic lvl_e lvl_decode(input logic [1:0] code);
      case (code)
         2'b00:   return LVL_LOW;
         2'b10:   return LVL_HIGH;
         default: return LVL_MID;
      endcase
   endfunction

   function automatic cmd_e cmd_from_lvl(input lvl_e lvl);
      case (lvl)
         LVL_HIGH: return CMD_HS;
         LVL_LOW:  return CMD_LS;
         default:  return CMD_MID;
      endcase
   endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hbg_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbg_wake_timer.sv
module hbg_wake_timer #(
   parameter int WAKE_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic wake_done
);

   generate
      if (WAKE_CYC < 0) begin : g_bad_wake
         $error("hbg_wake_timer: WAKE_CYC must not be negative");
      end

      if (WAKE_CYC == 0) begin : g_no_wait
         // No settling interval: ready as soon as the stage is enabled
         assign wake_done = active;
      end else begin : g_count
         localparam int CW = $clog2(WAKE_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(WAKE_CYC);

         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!active) begin
               cnt <= '0;
            end else if (cnt != LAST) begin
               cnt <= cnt + CW'(1);
            end
         end

         assign wake_done = (cnt == LAST);

         // R9: an idle stage never reports the interval as complete one cycle later
         a_r9_idle_not_done: assert property (@(posedge clk) disable iff (!rst_n)
            !active |=> !wake_done);
      end
   endgenerate

endmodule

// File: rtl/hbg_phase_ctrl.sv
module hbg_phase_ctrl
   import hbg_pkg::*;
#(
   parameter int HS_DLY  = 3,
   parameter int LS_DLY  = 2,
   parameter int MID_DLY = 3,
   parameter int TMO_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic allowed,
   input  logic en_low,
   input  cmd_e cmd,
   input  logic hs_fb_ok,
   input  logic ls_fb_ok,
   output logic hs_on,
   output logic ls_on,
   output logic fault
);

   generate
      if (HS_DLY < 1 || LS_DLY < 1 || MID_DLY < 1) begin : g_bad_dly
         $error("hbg_phase_ctrl: guard delays must be at least one cycle");
      end
      if (TMO_CYC < 1) begin : g_bad_tmo
         $error("hbg_phase_ctrl: TMO_CYC must be at least one cycle");
      end
   endgenerate

   localparam int DMAX_A = (HS_DLY > LS_DLY) ? HS_DLY : LS_DLY;
   localparam int DMAX   = (DMAX_A > MID_DLY) ? DMAX_A : MID_DLY;
   localparam int DW     = $clog2(DMAX) + 1;
   localparam int TW     = $clog2(TMO_CYC) + 1;

   localparam logic [DW-1:0] HS_LAST  = DW'(HS_DLY - 1);
   localparam logic [DW-1:0] LS_LAST  = DW'(LS_DLY - 1);
   localparam logic [DW-1:0] MID_LAST = DW'(MID_DLY - 1);
   localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

   phase_e        ph;
   logic [DW-1:0] dly;
   logic [TW-1:0] tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         dly   <= '0;
         tmo   <= '0;
         fault <= 1'b0;
      end else begin
         if (en_low) fault <= 1'b0;

         if (!allowed || fault) begin
            ph  <= PH_IDLE;
            dly <= '0;
            tmo <= '0;
         end else begin
            case (ph)
               PH_IDLE: begin
                  dly <= '0;
                  tmo <= '0;
                  if (cmd == CMD_HS)      ph <= PH_TO_HS;
                  else if (cmd == CMD_LS) ph <= PH_TO_LS;
               end

               PH_HS_ON: begin
                  dly <= '0;
                  tmo <= '0;
                  if (cmd == CMD_LS)       ph <= PH_TO_LS;
                  else if (cmd == CMD_MID) ph <= PH_MID_HOLD;
               end

               PH_LS_ON: begin
                  dly <= '0;
                  tmo <= '0;
                  if (cmd == CMD_HS)       ph <= PH_TO_HS;
                  else if (cmd == CMD_MID) ph <= PH_MID_HOLD;
               end

               PH_TO_HS: begin
                  if (cmd == CMD_MID) begin
                     ph  <= PH_MID_HOLD;
                     dly <= '0;
                     tmo <= '0;
                  end else if (cmd == CMD_LS) begin
                     ph  <= PH_TO_LS;
                     dly <= '0;
                     tmo <= '0;
                  end else if (ls_fb_ok) begin
                     tmo <= '0;
                     if (dly == HS_LAST) begin
                        ph  <= PH_HS_ON;
                        dly <= '0;
                     end else begin
                        dly <= dly + DW'(1);
                     end
                  end else begin
                     dly <= '0;
                     if (tmo == TMO_LAST) begin
                        fault <= 1'b1;
                        ph    <= PH_IDLE;
                        tmo   <= '0;
                     end else begin
                        tmo <= tmo + TW'(1);
                     end
                  end
               end

               PH_TO_LS: begin
                  if (cmd == CMD_MID) begin
                     ph  <= PH_MID_HOLD;
                     dly <= '0;
                     tmo <= '0;
                  end else if (cmd == CMD_HS) begin
                     ph  <= PH_TO_HS;
                     dly <= '0;
                     tmo <= '0;
                  end else if (hs_fb_ok) begin
                     tmo <= '0;
                     if (dly == LS_LAST) begin
                        ph  <= PH_LS_ON;
                        dly <= '0;
                     end else begin
                        dly <= dly + DW'(1);
                     end
                  end else begin
                     dly <= '0;
                     if (tmo == TMO_LAST) begin
                        fault <= 1'b1;
                        ph    <= PH_IDLE;
                        tmo   <= '0;
                     end else begin
                        tmo <= tmo + TW'(1);
                     end
                  end
               end

               PH_MID_HOLD: begin
                  tmo <= '0;
                  if (dly == MID_LAST) begin
                     ph  <= PH_IDLE;
                     dly <= '0;
                  end else begin
                     dly <= dly + DW'(1);
                  end
               end

               default: begin
                  ph  <= PH_IDLE;
                  dly <= '0;
                  tmo <= '0;
               end
            endcase
         end
      end
   end

   assign hs_on = (ph == PH_HS_ON);
   assign ls_on = (ph == PH_LS_ON);

   // R4: high side only turns on after the low-side gate was sensed discharged
   a_r4_hs_waits_ls_fb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_on) |-> $past(ls_fb_ok));

   // R5: low side only turns on after the high-side gate was sensed discharged
   a_r5_ls_waits_hs_fb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_on) |-> $past(hs_fb_ok));

   // R10: a latched fault keeps both switches off
   a_r10_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!hs_on && !ls_on));

   // R10: enable low clears the fault on the next edge
   a_r10_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
      en_low |=> !fault);

endmodule

// File: rtl/hbg_gate_seq.sv
module hbg_gate_seq
   import hbg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HS_DLY      = 3,
   parameter int LS_DLY      = 2,
   parameter int MID_DLY     = 3,
   parameter int WAKE_CYC    = 10000,
   parameter int TMO_CYC     = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwm_code,
   input  logic [1:0] en_code,
   input  logic       supply_good,
   input  logic       hs_gate_low,
   input  logic       ls_gate_low,
   output logic       hs_drive,
   output logic       ls_drive,
   output logic       fb_fault
);

   localparam int IN_W = 7;
   // Reset values: codes low, supply bad, both gates reported discharged
   localparam logic [IN_W-1:0] IN_RST = 7'b00_00_0_1_1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hbg_gate_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [IN_W-1:0] raw_in;
   logic [IN_W-1:0] syn_in;

   assign raw_in = {pwm_code, en_code, supply_good, hs_gate_low, ls_gate_low};

   hbg_sync #(
      .WIDTH   (IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   lvl_e pwm_lvl;
   lvl_e en_lvl;
   logic supply_s;
   logic hs_fb_s;
   logic ls_fb_s;

   assign pwm_lvl  = lvl_decode(syn_in[6:5]);
   assign en_lvl   = lvl_decode(syn_in[4:3]);
   assign supply_s = syn_in[2];
   assign hs_fb_s  = syn_in[1];
   assign ls_fb_s  = syn_in[0];

   logic stage_active;
   logic wake_done;
   logic allowed;
   cmd_e cmd;

   assign stage_active = supply_s && (en_lvl != LVL_LOW);

   hbg_wake_timer #(
      .WAKE_CYC (WAKE_CYC)
   ) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (stage_active),
      .wake_done (wake_done)
   );

   assign allowed = supply_s && (en_lvl == LVL_HIGH) && wake_done;
   assign cmd     = cmd_from_lvl(pwm_lvl);

   hbg_phase_ctrl #(
      .HS_DLY  (HS_DLY),
      .LS_DLY  (LS_DLY),
      .MID_DLY (MID_DLY),
      .TMO_CYC (TMO_CYC)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .allowed  (allowed),
      .en_low   (en_lvl == LVL_LOW),
      .cmd      (cmd),
      .hs_fb_ok (hs_fb_s),
      .ls_fb_ok (ls_fb_s),
      .hs_on    (hs_drive),
      .ls_on    (ls_drive),
      .fault    (fb_fault)
   );

   // R1: enable low switches both gates off on the following edge
   a_r1_en_low_off: assert property (@(posedge clk) disable iff (!rst_n)
      (en_lvl == LVL_LOW) |=> (!hs_drive && !ls_drive));

   // R8: supply not good switches both gates off on the following edge
   a_r8_supply_low_off: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_s |=> (!hs_drive && !ls_drive));

   // R9: before the settling interval completes, both gates are off
   a_r9_wake_off: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_done |-> (!hs_drive && !ls_drive));

endmodule

// File: tb/tb_hbg_gate_seq.sv
module tb_hbg_gate_seq;

   localparam int HS_DLY  = 3;
   localparam int LS_DLY  = 2;
   localparam int MID_DLY = 4;
   localparam int WAKE    = 20;
   localparam int TMO     = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] pwm_code;
   logic [1:0] en_code;
   logic       supply_good;
   logic       hs_gate_low;
   logic       ls_gate_low;
   logic       hs_drive;
   logic       ls_drive;
   logic       fb_fault;

   always #5 clk = ~clk;

   hbg_gate_seq #(
      .SYNC_STAGES (2),
      .HS_DLY      (HS_DLY),
      .LS_DLY      (LS_DLY),
      .MID_DLY     (MID_DLY),
      .WAKE_CYC    (WAKE),
      .TMO_CYC     (TMO)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwm_code    (pwm_code),
      .en_code     (en_code),
      .supply_good (supply_good),
      .hs_gate_low (hs_gate_low),
      .ls_gate_low (ls_gate_low),
      .hs_drive    (hs_drive),
      .ls_drive    (ls_drive),
      .fb_fault    (fb_fault)
   );

   // Power-stage model: each gate reads as discharged one cycle after its drive drops
   logic auto_fb;
   logic hs_man;
   logic ls_man;
   logic hs_auto;
   logic ls_auto;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_auto <= 1'b1;
         ls_auto <= 1'b1;
      end else begin
         hs_auto <= !hs_drive;
         ls_auto <= !ls_drive;
      end
   end

   assign hs_gate_low = auto_fb ? hs_auto : hs_man;
   assign ls_gate_low = auto_fb ? ls_auto : ls_man;

   // Scoreboard
   typedef struct {
      int unsigned due;
      string       req;
      logic        hs;
      logic        ls;
      logic        flt;
   } exp_t;

   exp_t        sb[$];
   int unsigned cyc = 0;
   int          n_checks = 0;
   int          n_err = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_in(input int unsigned n, input string req,
                            input logic hs, input logic ls, input logic flt);
      exp_t e;
      e.due = cyc + n;
      e.req = req;
      e.hs  = hs;
      e.ls  = ls;
      e.flt = flt;
      sb.push_back(e);
   endtask

   // Monitor: compares due items away from the active edge
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            n_checks++;
            if (hs_drive !== sb[i].hs || ls_drive !== sb[i].ls || fb_fault !== sb[i].flt) begin
               n_err++;
               $display("FAIL %s: got hs=%b ls=%b flt=%b, expected hs=%b ls=%b flt=%b",
                        sb[i].req, hs_drive, ls_drive, fb_fault, sb[i].hs, sb[i].ls, sb[i].flt);
            end
            sb.delete(i);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run still active, expected completion before the limit");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      pwm_code    = 2'b00;
      en_code     = 2'b00;
      supply_good = 1'b1;
      auto_fb     = 1'b1;
      hs_man      = 1'b1;
      ls_man      = 1'b1;
      step(2);
      expect_in(1, "R1 reset state", 1'b0, 1'b0, 1'b0);
      step(3);
      rst_n = 1'b1;
      step(3);

      // R9: enable with PWM low; low side only after the settling interval
      en_code = 2'b10;
      expect_in(24, "R9 held off during settling", 1'b0, 1'b0, 1'b0);
      expect_in(25, "R9 low side after settling", 1'b0, 1'b1, 1'b0);
      step(27);

      // R11, R4: PWM to high
      pwm_code = 2'b10;
      expect_in(2, "R11 no change before third edge", 1'b0, 1'b1, 1'b0);
      expect_in(3, "R4 low side off first", 1'b0, 1'b0, 1'b0);
      expect_in(8, "R4 high side waits feedback plus delay", 1'b0, 1'b0, 1'b0);
      expect_in(9, "R4 high side on", 1'b1, 1'b0, 1'b0);
      expect_in(11, "R3 high only", 1'b1, 1'b0, 1'b0);
      step(12);

      // R5: PWM to low
      pwm_code = 2'b00;
      expect_in(2, "R11 no change before third edge", 1'b1, 1'b0, 1'b0);
      expect_in(3, "R5 high side off first", 1'b0, 1'b0, 1'b0);
      expect_in(7, "R5 low side waits feedback plus delay", 1'b0, 1'b0, 1'b0);
      expect_in(8, "R5 low side on", 1'b0, 1'b1, 1'b0);
      expect_in(9, "R3 low only", 1'b0, 1'b1, 1'b0);
      step(10);

      // R6: PWM held mid
      pwm_code = 2'b01;
      expect_in(3, "R6 mid forces off", 1'b0, 1'b0, 1'b0);
      expect_in(15, "R6 still mid stays off", 1'b0, 1'b0, 1'b0);
      step(16);
      pwm_code = 2'b10;
      expect_in(5, "R6 leaving mid guarded", 1'b0, 1'b0, 1'b0);
      expect_in(6, "R6 high after mid", 1'b1, 1'b0, 1'b0);
      step(8);

      // R6: one-cycle mid pulse still costs the full mid hold
      pwm_code = 2'b01;
      expect_in(3, "R6 mid pulse forces off", 1'b0, 1'b0, 1'b0);
      expect_in(10, "R6 mid hold then guard", 1'b0, 1'b0, 1'b0);
      expect_in(11, "R6 high after mid hold", 1'b1, 1'b0, 1'b0);
      step(1);
      pwm_code = 2'b10;
      step(12);

      // R7: reserved code behaves as mid
      pwm_code = 2'b11;
      expect_in(3, "R7 reserved code forces off", 1'b0, 1'b0, 1'b0);
      expect_in(15, "R7 reserved code stays off", 1'b0, 1'b0, 1'b0);
      step(16);
      pwm_code = 2'b00;
      expect_in(4, "R5 guarded after reserved", 1'b0, 1'b0, 1'b0);
      expect_in(5, "R5 low side after reserved", 1'b0, 1'b1, 1'b0);
      step(7);

      // R2: enable mid holds off, return to high needs no new settling
      pwm_code = 2'b10;
      en_code  = 2'b01;
      expect_in(3, "R2 enable mid forces off", 1'b0, 1'b0, 1'b0);
      expect_in(12, "R2 enable mid ignores PWM", 1'b0, 1'b0, 1'b0);
      step(13);
      en_code = 2'b10;
      expect_in(5, "R2 guard after mid enable", 1'b0, 1'b0, 1'b0);
      expect_in(6, "R2 no settling after mid enable", 1'b1, 1'b0, 1'b0);
      step(8);

      // R1: enable low, PWM ignored, settling restarts
      en_code = 2'b00;
      expect_in(3, "R1 enable low forces off", 1'b0, 1'b0, 1'b0);
      expect_in(12, "R1 PWM ignored while disabled", 1'b0, 1'b0, 1'b0);
      step(4);
      pwm_code = 2'b00;
      step(5);
      pwm_code = 2'b10;
      step(5);
      en_code = 2'b10;
      expect_in(25, "R1 settling restarted", 1'b0, 1'b0, 1'b0);
      expect_in(26, "R1 high side after settling", 1'b1, 1'b0, 1'b0);
      step(28);

      // R8: supply flag drop
      supply_good = 1'b0;
      expect_in(3, "R8 supply bad forces off", 1'b0, 1'b0, 1'b0);
      expect_in(9, "R8 supply bad stays off", 1'b0, 1'b0, 1'b0);
      step(10);
      supply_good = 1'b1;
      expect_in(25, "R8 settling after supply returns", 1'b0, 1'b0, 1'b0);
      expect_in(26, "R8 high side after settling", 1'b1, 1'b0, 1'b0);
      step(28);

      // R10: high-side feedback stuck while PWM goes low
      hs_man   = 1'b0;
      ls_man   = 1'b1;
      auto_fb  = 1'b0;
      pwm_code = 2'b00;
      expect_in(12, "R10 no fault before timeout", 1'b0, 1'b0, 1'b0);
      expect_in(13, "R10 fault on timeout", 1'b0, 1'b0, 1'b1);
      expect_in(25, "R10 fault sticky after feedback recovers", 1'b0, 1'b0, 1'b1);
      step(15);
      hs_man = 1'b1;
      step(11);
      en_code = 2'b00;
      expect_in(2, "R10 fault held until enable low seen", 1'b0, 1'b0, 1'b1);
      expect_in(3, "R10 enable low clears fault", 1'b0, 1'b0, 1'b0);
      step(5);
      auto_fb = 1'b1;
      en_code = 2'b10;
      expect_in(25, "R10 normal operation after clear", 1'b0, 1'b1, 1'b0);
      step(27);

      // R10: low-side feedback stuck, fault cleared by reset
      hs_man   = 1'b1;
      ls_man   = 1'b0;
      auto_fb  = 1'b0;
      pwm_code = 2'b10;
      expect_in(12, "R10 no fault before timeout", 1'b0, 1'b0, 1'b0);
      expect_in(13, "R10 fault on low-side timeout", 1'b0, 1'b0, 1'b1);
      step(15);
      rst_n = 1'b0;
      expect_in(1, "R10 reset clears fault", 1'b0, 1'b0, 1'b0);
      step(3);
      rst_n = 1'b1;
      step(3);

      if (sb.size() != 0) begin
         n_err++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule